// File: doc/BRIEF.md
# Width-Expanded Dual-Clock FIFO

This block forms one wide first-in first-out buffer that crosses between two unrelated clocks. It is made from several identical narrow lanes placed side by side. Each lane is a complete asynchronous FIFO of its own, with its own storage, Gray-coded pointers and synchronizers. A write word is cut into lane-wide slices, and every lane takes one slice on the same write strobe. On a read, every lane pops its slice on the same read strobe, and the slices are joined again in their original order.

Each lane computes its own status flags, and one OR gate per flag merges them into the combined flags. The merged flags decide whether an access is accepted. Every lane therefore accepts or refuses each access together, and no lane can run ahead of another. The merge is kept to a single gate level because it sits on the path from the flags back to the enables. With the defaults there are two lanes of 72 bits and 512 entries, giving a 144-bit word. The almost-full flag rises when 16 or fewer free entries remain.

Top module: `wide_fifo`

## Requirements
- R1: Bits [LANE_W-1:0] of the write word go to lane 0, the next LANE_W bits go to lane 1, and so on. The read word is assembled in the same bit order, and words leave in the order they were written.
- R2: While and after reset, fifo_empty is 1, near_full is 0 and rd_word is all zeros.
- R3: A write presented while any lane is full is dropped by every lane. After DEPTH accepted writes, one further write does not appear in the read stream.
- R4: A read presented while fifo_empty is 1 is ignored. rd_word keeps its previous value and no pointer moves.
- R5: fifo_empty is the OR of the lane empty flags. It falls within a few rd_clk cycles after a write and rises on the rd_clk edge that pops the last stored word.
- R6: near_full is the OR of the lane almost-full flags. With no reads pending, it is 1 exactly when the written count is at least DEPTH-AF_FREE, and it updates on the wr_clk edge that accepts the write.
- R7: All lanes hold equal write pointers and equal read pointers at all times.
- R8: rd_word takes the popped word on the rd_clk edge that accepts the read.
- R9: near_full falls within a few wr_clk cycles once reads bring the written-minus-read count below DEPTH-AF_FREE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_en | input | 1 | Write request |
| wr_word | input | LANES*LANE_W | Word to store |
| near_full | output | 1 | Combined almost-full flag (write domain) |
| rd_en | input | 1 | Read request |
| rd_word | output | LANES*LANE_W | Last popped word |
| fifo_empty | output | 1 | Combined empty flag (read domain) |

## Verification
The bench keeps the default two 72-bit lanes, so the full 144-bit split and rejoin is exercised. It reduces the depth to 16 entries (ADDR_W=4) and sets AF_FREE to 3. With those values, the almost-full edge, the full limit with a dropped extra write, and the Gray pointer wrap are all reached in a few dozen accesses. The write clock and the read clock run at unrelated rates, so the flag synchronizers are exercised with shifting phase.

// File: rtl/wide_fifo.sv
module wide_fifo #(
  parameter int LANE_W  = 72,
  parameter int LANES   = 2,
  parameter int ADDR_W  = 9,
  parameter int AF_FREE = 16,
  localparam int W      = LANES * LANE_W,
  localparam int DEPTH  = 1 << ADDR_W,
  localparam int PW     = ADDR_W + 1
) (
  input  logic         wr_clk,
  input  logic         rd_clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_word,
  output logic         near_full,
  input  logic         rd_en,
  output logic [W-1:0] rd_word,
  output logic         fifo_empty
);

  logic [LANES-1:0] lane_full, lane_empty, lane_nf;
  logic             full_any, wr_go, rd_go;
  logic [LANES*PW-1:0] wptr_flat, rptr_flat;

  assign full_any   = |lane_full;
  assign fifo_empty = |lane_empty;
  assign near_full  = |lane_nf;
  assign wr_go      = wr_en & ~full_any;
  assign rd_go      = rd_en & ~fifo_empty;

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] q;
    logic [PW-1:0] wbin, wgray, wbin_nx;
    logic [PW-1:0] rbin, rgray, rbin_nx;
    logic [PW-1:0] rs1, rs2, ws1, ws2;
    logic [PW-1:0] used_w;

    assign wbin_nx = wbin + PW'(1);
    assign rbin_nx = rbin + PW'(1);

    always_ff @(posedge wr_clk or negedge rst_n)
      if (!rst_n) begin
        wbin  <= '0;
        wgray <= '0;
      end else if (wr_go) begin
        wbin  <= wbin_nx;
        wgray <= wbin_nx ^ (wbin_nx >> 1);
      end

    always_ff @(posedge wr_clk)
      if (wr_go) mem[wbin[ADDR_W-1:0]] <= wr_word[l*LANE_W +: LANE_W];

    always_ff @(posedge wr_clk or negedge rst_n)
      if (!rst_n) {rs2, rs1} <= '0;
      else        {rs2, rs1} <= {rs1, rgray};

    assign lane_full[l] = (wgray == {~rs2[PW-1:PW-2], rs2[PW-3:0]});
    assign used_w       = wbin - g2b(rs2);
    assign lane_nf[l]   = (used_w >= PW'(DEPTH - AF_FREE));

    always_ff @(posedge rd_clk or negedge rst_n)
      if (!rst_n) begin
        rbin  <= '0;
        rgray <= '0;
        q     <= '0;
      end else if (rd_go) begin
        rbin  <= rbin_nx;
        rgray <= rbin_nx ^ (rbin_nx >> 1);
        q     <= mem[rbin[ADDR_W-1:0]];
      end

    always_ff @(posedge rd_clk or negedge rst_n)
      if (!rst_n) {ws2, ws1} <= '0;
      else        {ws2, ws1} <= {ws1, wgray};

    assign lane_empty[l]               = (rgray == ws2);
    assign rd_word[l*LANE_W +: LANE_W] = q;
    assign wptr_flat[l*PW +: PW]       = wbin;
    assign rptr_flat[l*PW +: PW]       = rbin;
  end

endmodule

// File: rtl/wide_fifo_chk.sv
module wide_fifo_chk #(
  parameter int LANES = 2,
  parameter int PW    = 10,
  parameter int W     = 144
) (
  input logic             wr_clk,
  input logic             rd_clk,
  input logic             rst_n,
  input logic             full_any,
  input logic             near_full,
  input logic             fifo_empty,
  input logic [LANES-1:0] lane_empty,
  input logic [LANES-1:0] lane_nf,
  input logic [W-1:0]     rd_word,
  input logic [LANES*PW-1:0] wptr_flat,
  input logic [LANES*PW-1:0] rptr_flat
);

  assert_no_overflow_R3: assert property (@(posedge wr_clk) disable iff (!rst_n)
    full_any |=> $stable(wptr_flat));

  assert_no_underflow_R4: assert property (@(posedge rd_clk) disable iff (!rst_n)
    fifo_empty |=> ($stable(rptr_flat) && $stable(rd_word)));

  assert_full_implies_nf_R6: assert property (@(posedge wr_clk) disable iff (!rst_n)
    full_any |-> near_full);

  for (genvar l = 0; l < LANES; l++) begin : g_chk
    assert_lane_empty_R5: assert property (@(posedge rd_clk) disable iff (!rst_n)
      lane_empty[l] |-> fifo_empty);
    assert_lane_nf_R6: assert property (@(posedge wr_clk) disable iff (!rst_n)
      lane_nf[l] |-> near_full);
    if (l > 0) begin : g_pair
      assert_wr_aligned_R7: assert property (@(posedge wr_clk) disable iff (!rst_n)
        wptr_flat[l*PW +: PW] == wptr_flat[PW-1:0]);
      assert_rd_aligned_R7: assert property (@(posedge rd_clk) disable iff (!rst_n)
        rptr_flat[l*PW +: PW] == rptr_flat[PW-1:0]);
    end
  end

endmodule

bind wide_fifo wide_fifo_chk #(.LANES(LANES), .PW(PW), .W(W)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .full_any(full_any),
  .near_full(near_full), .fifo_empty(fifo_empty), .lane_empty(lane_empty),
  .lane_nf(lane_nf), .rd_word(rd_word), .wptr_flat(wptr_flat), .rptr_flat(rptr_flat)
);

// File: tb/wide_fifo_bench.sv
`timescale 1ns/1ps
module wide_fifo_bench;
  localparam int LANE_W = 72;
  localparam int LANES  = 2;
  localparam int AW     = 4;
  localparam int AF     = 3;
  localparam int DEPTH  = 1 << AW;
  localparam int W      = LANE_W * LANES;

  logic wr_clk = 0, rd_clk = 0, rst_n = 1;
  logic wr_en = 0, rd_en = 0;
  logic [W-1:0] wr_word = '0;
  logic [W-1:0] rd_word;
  logic near_full, fifo_empty;
  int total = 0, bad = 0;
  bit done = 0;
  logic [W-1:0] expq [$];

  always #2   wr_clk = ~wr_clk;
  always #3.5 rd_clk = ~rd_clk;

  wide_fifo #(.LANE_W(LANE_W), .LANES(LANES), .ADDR_W(AW), .AF_FREE(AF)) u_wide_fifo (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word),
    .near_full(near_full), .rd_en(rd_en), .rd_word(rd_word), .fifo_empty(fifo_empty));

  function automatic logic [W-1:0] mk(int k);
    return {8'(k), 64'hC0DE_0000_0000_0000 ^ 64'(k * 3), 8'(~k), 64'(k * 17 + 5)};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic [W-1:0] d);
    @(negedge wr_clk); wr_en = 1; wr_word = d;
    @(negedge wr_clk); wr_en = 0;
  endtask

  task automatic pop(output logic [W-1:0] got);
    @(negedge rd_clk); rd_en = 1;
    @(negedge rd_clk); rd_en = 0; got = rd_word;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(negedge wr_clk); @(negedge rd_clk); end
  endtask

  task automatic t_reset;
    @(negedge rd_clk);
    chk(fifo_empty == 1'b1, "R2 empty", W'(fifo_empty), W'(1));
    chk(near_full == 1'b0, "R2 near_full", W'(near_full), W'(0));
    chk(rd_word == '0, "R2 rd_word", rd_word, '0);
  endtask

  task automatic t_basic;
    logic [W-1:0] g;
    for (int k = 1; k <= 3; k++) push(mk(k));
    idle(4);
    chk(fifo_empty == 1'b0, "R5 empty falls", W'(fifo_empty), W'(0));
    for (int k = 1; k <= 3; k++) begin
      pop(g);
      chk(g == mk(k), "R1 R8 order and split", g, mk(k));
    end
    chk(fifo_empty == 1'b1, "R5 empty rises", W'(fifo_empty), W'(1));
  endtask

  task automatic t_underflow;
    logic [W-1:0] g;
    pop(g);
    chk(g == mk(3), "R4 read on empty holds", g, mk(3));
    push(mk(40));
    idle(4);
    pop(g);
    chk(g == mk(40), "R4 pointer not moved", g, mk(40));
  endtask

  task automatic t_fill;
    logic [W-1:0] g;
    idle(4);
    for (int k = 1; k <= DEPTH; k++) begin
      push(mk(100 + k));
      expq.push_back(mk(100 + k));
      chk(near_full == (k >= DEPTH - AF), "R6 near_full threshold", W'(near_full), W'(k >= DEPTH - AF));
    end
    push(mk(999));
    idle(4);
    chk(near_full == 1'b1, "R6 near_full when full", W'(near_full), W'(1));
    for (int j = 1; j <= DEPTH; j++) begin
      pop(g);
      chk(g == expq[0], "R3 R1 drain order", g, expq[0]);
      void'(expq.pop_front());
      if (j == AF + 1) begin
        idle(5);
        chk(near_full == 1'b0, "R9 near_full clears", W'(near_full), W'(0));
      end
    end
    chk(fifo_empty == 1'b1, "R3 extra write dropped", W'(fifo_empty), W'(1));
    pop(g);
    chk(g == mk(100 + DEPTH), "R4 hold after drain", g, mk(100 + DEPTH));
  endtask

  initial begin
    #1 rst_n = 0;
    #20 t_reset();
    @(negedge wr_clk); rst_n = 1;
    idle(2);
    t_reset();
    t_basic();
    t_underflow();
    t_fill();
    t_fill();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule